// File: doc/BRIEF.md
# Overload Protection Leaky Timer

This block watches the current comparators of one powered port and decides when the port must be shut down. It is enabled when power-up begins. From that point it selects the fixed inrush current limit, waits for the pass device gate to report fully on, and then switches to the class-specific limit. All timing is paced by a 1 ms tick supplied from outside. Comparator flags, threshold values and the gate drive itself belong to neighbouring logic.

Three independent watchdogs run while the port is enabled. The inrush window guards the power-up phase. A leaky overcurrent timer rises quickly while current sits above the cut threshold and drains slowly when it falls back below. A limit-dwell check is used only for high-power-class ports. The first watchdog to expire latches a two-bit cause code and emits a one-clock fault pulse, which the gate driver uses to switch the pass device off. The code stays latched until enable is removed.

Top module: `olp_guard`

## Requirements
- R1: After enable rises, `lim_sel` is 0 (inrush limit). It becomes 1 (class limit) one clock after `gate_full` is seen with the ramp count satisfied. It then stays 1 until enable drops, even if `gate_full` falls.
- R2: `gate_full` is ignored until RAMP_MS (5) ticks have elapsed since enable. During that time `lim_sel` stays 0.
- R3: If the gate has not been accepted as fully on by the WINDOW_MS-th (75th) tick after enable, the cause becomes 2'b10 (inrush timeout) on the clock after that tick.
- R4: Once the class limit is selected, an overcurrent count gains 16 per tick with `above_cut` high and loses 1 per tick with it low. When the count reaches 960, the cause becomes 2'b01 (overcurrent). From zero, this takes 60 ticks of `above_cut`.
- R5: The overcurrent count never drops below zero. Ticks below threshold at a count of zero leave it at zero.
- R6: The overcurrent timer and the dwell check do not advance while the inrush limit is selected.
- R7: With `hp_class` high and the class limit selected, 16 consecutive ticks with `in_limit` high set the cause to 2'b11 (high-power limit dwell). A tick with `in_limit` low restarts the run. With `hp_class` low, `in_limit` never causes a fault.
- R8: If the dwell and overcurrent conditions expire on the same tick, the cause is 2'b11.
- R9: A fault produces exactly one `fault_pulse` clock, in the same cycle the cause appears. The cause then holds, and no further pulse occurs until enable drops.
- R10: With enable low, on the next clock the cause returns to 2'b00, `lim_sel` returns to 0, and all counts clear.
- R11: While `rst_n` is low, the cause is 2'b00, `lim_sel` is 0 and `fault_pulse` is 0. Each count starts from zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | High from start of power-up; low clears the block |
| tick_ms | input | 1 | One-clock strobe every millisecond |
| above_cut | input | 1 | Output current above the cut threshold |
| in_limit | input | 1 | Current limiter is active |
| gate_full | input | 1 | Pass device gate reports fully on |
| hp_class | input | 1 | Port was granted the high-power class |
| lim_sel | output | 1 | 0 = inrush limit, 1 = class limit |
| fault_pulse | output | 1 | One-clock strobe: turn the pass device off |
| fault_cause | output | 2 | 00 none, 01 overcurrent, 10 inrush, 11 high-power dwell |

## Verification
A leaky count that drifts by even one sub-step moves the overcurrent trip by a whole tick. Mixed rise and decay patterns are therefore checked on the exact tick where the cause should appear, and on the tick before it. A count that wraps below zero, or a dwell counter that fails to restart, shows up as an early cause code within one tick of the faulty step. A latch that fails to freeze appears as a second fault pulse or a changed code during the idle ticks after a fault.

// File: rtl/olp_pkg.sv
package olp_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_OVERCUR  = 2'b01,
    CAUSE_INRUSH   = 2'b10,
    CAUSE_HP_DWELL = 2'b11
  } cause_e;

  // Leaky step: rise by up when above threshold, fall by dn otherwise, floor at zero.
  function automatic int unsigned leak_next(input int unsigned cur, input logic above,
                                            input int unsigned up, input int unsigned dn);
    if (above) return cur + up;
    if (cur > dn) return cur - dn;
    return 0;
  endfunction

  // Dwell outranks inrush outranks overcurrent (inrush and the other two are exclusive by phase).
  function automatic cause_e pick_cause(input logic oc, input logic inr, input logic dw);
    if (dw)  return CAUSE_HP_DWELL;
    if (inr) return CAUSE_INRUSH;
    if (oc)  return CAUSE_OVERCUR;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/olp_leaky_timer.sv
module olp_leaky_timer
  import olp_pkg::*;
#(
  parameter int unsigned LIMIT = 960,
  parameter int unsigned UP    = 16,
  parameter int unsigned DOWN  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  input  logic above,
  output logic trip
);
  localparam int unsigned CW = $clog2(LIMIT + UP + 1);
  localparam logic [CW-1:0] UP_C   = CW'(UP);
  localparam logic [CW-1:0] DOWN_C = CW'(DOWN);

  logic [CW-1:0] cnt_q;
  logic          step;
  int unsigned   nxt;

  assign step = run && tick;

  always_comb nxt = leak_next(32'(cnt_q), above, UP, DOWN);

  assign trip = step && above && (nxt >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (step)  cnt_q <= CW'(nxt);
  end

  a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
    step && above |=> cnt_q == $past(cnt_q) + UP_C);
  a_r4_fall: assert property (@(posedge clk) disable iff (!rst_n)
    step && !above && cnt_q >= DOWN_C |=> cnt_q == $past(cnt_q) - DOWN_C);
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    step && !above && cnt_q == '0 |=> cnt_q == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clr |=> $stable(cnt_q));

endmodule

// File: rtl/olp_inrush_window.sv
module olp_inrush_window #(
  parameter int unsigned RAMP   = 5,
  parameter int unsigned WINDOW = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  input  logic gate_full,
  output logic gate_on,
  output logic trip
);
  localparam int unsigned IW = $clog2(WINDOW + 1);
  localparam logic [IW-1:0] RAMP_C = IW'(RAMP);
  localparam logic [IW-1:0] LAST_C = IW'(WINDOW - 1);
  localparam logic [IW-1:0] WIN_C  = IW'(WINDOW);

  logic [IW-1:0] icnt_q;
  logic          gate_on_q;
  logic          promote;

  assign promote = run && gate_full && (icnt_q >= RAMP_C);
  assign trip    = run && tick && !promote && (icnt_q == LAST_C);
  assign gate_on = gate_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q    <= '0;
      gate_on_q <= 1'b0;
    end else if (clr) begin
      icnt_q    <= '0;
      gate_on_q <= 1'b0;
    end else begin
      if (run && tick && icnt_q < WIN_C) icnt_q <= icnt_q + 1'b1;
      if (promote) gate_on_q <= 1'b1;
    end
  end

  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on_q && icnt_q < RAMP_C |=> !gate_on_q);
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on_q && !clr |=> gate_on_q);
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_q <= WIN_C);

endmodule

// File: rtl/olp_dwell_check.sv
module olp_dwell_check #(
  parameter int unsigned DWELL = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  input  logic in_limit,
  output logic trip
);
  localparam int unsigned DW = $clog2(DWELL + 2);
  localparam logic [DW-1:0] DWELL_C = DW'(DWELL);

  logic [DW-1:0] dcnt_q;
  logic          step;

  assign step = run && tick;
  assign trip = step && in_limit && (dcnt_q == DWELL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dcnt_q <= '0;
    else if (clr || !run)  dcnt_q <= '0;
    else if (step)         dcnt_q <= in_limit ? dcnt_q + 1'b1 : '0;
  end

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    step && !in_limit |=> dcnt_q == '0);
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= DWELL_C + 1'b1);

endmodule

// File: rtl/olp_guard.sv
module olp_guard
  import olp_pkg::*;
#(
  parameter int unsigned OC_LIMIT  = 960,
  parameter int unsigned OC_UP     = 16,
  parameter int unsigned OC_DOWN   = 1,
  parameter int unsigned RAMP_MS   = 5,
  parameter int unsigned WINDOW_MS = 75,
  parameter int unsigned DWELL_MS  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick_ms,
  input  logic       above_cut,
  input  logic       in_limit,
  input  logic       gate_full,
  input  logic       hp_class,
  output logic       lim_sel,
  output logic       fault_pulse,
  output logic [1:0] fault_cause
);
  cause_e cause_q;
  cause_e next_cause;
  logic   pulse_q;
  logic   clr;
  logic   faulted;
  logic   gate_on;
  logic   run_inrush;
  logic   run_class;
  logic   run_dwell;
  logic   oc_trip;
  logic   inr_trip;
  logic   dw_trip;

  assign clr        = !en;
  assign faulted    = (cause_q != CAUSE_NONE);
  assign run_inrush = en && !faulted && !gate_on;
  assign run_class  = en && !faulted && gate_on;
  assign run_dwell  = run_class && hp_class;

  olp_inrush_window #(.RAMP(RAMP_MS), .WINDOW(WINDOW_MS)) u_inrush (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run_inrush), .tick(tick_ms),
    .gate_full(gate_full), .gate_on(gate_on), .trip(inr_trip)
  );

  olp_leaky_timer #(.LIMIT(OC_LIMIT), .UP(OC_UP), .DOWN(OC_DOWN)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run_class), .tick(tick_ms),
    .above(above_cut), .trip(oc_trip)
  );

  olp_dwell_check #(.DWELL(DWELL_MS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run_dwell), .tick(tick_ms),
    .in_limit(in_limit), .trip(dw_trip)
  );

  always_comb next_cause = pick_cause(oc_trip, inr_trip, dw_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      pulse_q <= 1'b0;
    end else if (clr) begin
      cause_q <= CAUSE_NONE;
      pulse_q <= 1'b0;
    end else if (!faulted && next_cause != CAUSE_NONE) begin
      cause_q <= next_cause;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign lim_sel     = gate_on;
  assign fault_pulse = pulse_q;
  assign fault_cause = cause_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);
  a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> fault_cause != 2'b00);
  a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en && fault_cause != 2'b00 |=> $stable(fault_cause));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> fault_cause == 2'b00 && !lim_sel && !fault_pulse);
  a_r3_inrush_phase: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse && fault_cause == 2'b10 |-> !lim_sel);
  a_r6_class_phase: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse && fault_cause[0] |-> lim_sel);
  a_r1_sel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en && lim_sel |=> lim_sel);

endmodule

// File: tb/test_olp_guard.sv
module test_olp_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick_ms = 1'b0;
  logic       above_cut = 1'b0;
  logic       in_limit = 1'b0;
  logic       gate_full = 1'b0;
  logic       hp_class = 1'b0;
  logic       lim_sel;
  logic       fault_pulse;
  logic [1:0] fault_cause;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  olp_guard i_olp_guard (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_ms(tick_ms), .above_cut(above_cut),
    .in_limit(in_limit), .gate_full(gate_full), .hp_class(hp_class),
    .lim_sel(lim_sel), .fault_pulse(fault_pulse), .fault_cause(fault_cause)
  );

  always @(negedge clk) if (fault_pulse) pulses++;

  typedef struct packed {
    logic       en;
    logic       above;
    logic       inl;
    logic       gate;
    logic       hp;
    logic [7:0] ticks;
    logic [1:0] cause;
    logic       sel;
    logic [1:0] npulse;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 39;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd74, 2'd0,1'b0,2'd0, 4'd3},  // R3 one tick short of window
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd1,  2'd2,1'b0,2'd1, 4'd3},  // R3 inrush timeout
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10 clear
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd2},  // R2 gate during ramp ignored
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd4,  2'd0,1'b0,2'd0, 4'd2},  // R2 still in ramp
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd1,  2'd0,1'b1,2'd0, 4'd1},  // R1 class limit selected
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd59, 2'd0,1'b1,2'd0, 4'd4},  // R4 944, no trip
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'd1,1'b1,2'd1, 4'd4},  // R4 trip at 960
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd5,  2'd0,1'b1,2'd0, 4'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd30, 2'd0,1'b1,2'd0, 4'd4},  // R4 480
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd16, 2'd0,1'b1,2'd0, 4'd4},  // R4 decay to 464
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd30, 2'd0,1'b1,2'd0, 4'd4},  // R4 944
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'd1,1'b1,2'd1, 4'd4},  // R4 trip after decay
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd5,  2'd0,1'b1,2'd0, 4'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'd0,1'b1,2'd0, 4'd5},  // R5 16
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd40, 2'd0,1'b1,2'd0, 4'd5},  // R5 floor at 0
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd59, 2'd0,1'b1,2'd0, 4'd5},  // R5 944 from floor
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd1,  2'd1,1'b1,2'd1, 4'd5},  // R5 trip on 60th
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 8'd5,  2'd0,1'b1,2'd0, 4'd1},  // R1
    '{1'b1,1'b0,1'b1,1'b1,1'b1, 8'd15, 2'd0,1'b1,2'd0, 4'd7},  // R7 15 ticks ok
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 8'd1,  2'd0,1'b1,2'd0, 4'd7},  // R7 restart
    '{1'b1,1'b0,1'b1,1'b1,1'b1, 8'd15, 2'd0,1'b1,2'd0, 4'd7},  // R7 15 again
    '{1'b1,1'b0,1'b1,1'b1,1'b1, 8'd1,  2'd3,1'b1,2'd1, 4'd7},  // R7 16th tick trips
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd5,  2'd0,1'b1,2'd0, 4'd1},  // R1
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 8'd40, 2'd0,1'b1,2'd0, 4'd7},  // R7 non-hp ignores limit
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 8'd5,  2'd0,1'b1,2'd0, 4'd1},  // R1
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 8'd44, 2'd0,1'b1,2'd0, 4'd8},  // R8 704
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'd15, 2'd0,1'b1,2'd0, 4'd8},  // R8 944, dwell 15
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'd1,  2'd3,1'b1,2'd1, 4'd8},  // R8 both expire, dwell wins
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'd100,2'd3,1'b1,2'd0, 4'd9},  // R9 held, no new pulse
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0,  2'd0,1'b0,2'd0, 4'd10}, // R10
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 8'd40, 2'd0,1'b0,2'd0, 4'd6},  // R6 nothing counts in inrush
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 8'd0,  2'd0,1'b1,2'd0, 4'd1},  // R1 promote late
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3,  2'd0,1'b1,2'd0, 4'd1}   // R1 sticky after gate drops
  };

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(input row_t r);
    @(negedge clk);
    en = r.en; above_cut = r.above; in_limit = r.inl; gate_full = r.gate; hp_class = r.hp;
    pulses = 0;
    ticks(int'(r.ticks));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset cause", int'(fault_cause), 0);
    check("R11 reset lim_sel", int'(lim_sel), 0);
    check("R11 reset pulse", int'(fault_pulse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      apply(ROWS[i]);
      check($sformatf("R%0d row %0d cause", ROWS[i].req, i), int'(fault_cause), int'(ROWS[i].cause));
      check($sformatf("R%0d row %0d lim_sel", ROWS[i].req, i), int'(lim_sel), int'(ROWS[i].sel));
      check($sformatf("R%0d row %0d pulses", ROWS[i].req, i), pulses, int'(ROWS[i].npulse));
    end

    // R11 directed: reset in mid-run clears every count
    apply('{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0, 2'd0,1'b0,2'd0, 4'd11});
    apply('{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd5, 2'd0,1'b1,2'd0, 4'd11});
    apply('{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd59, 2'd0,1'b1,2'd0, 4'd11});
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid reset cause", int'(fault_cause), 0);
    check("R11 mid reset lim_sel", int'(lim_sel), 0);
    @(negedge clk) rst_n = 1'b1;
    above_cut = 1'b0;
    ticks(4);
    check("R11 ramp restarted lim_sel", int'(lim_sel), 0);
    ticks(1);
    check("R11 promoted again", int'(lim_sel), 1);
    above_cut = 1'b1;
    pulses = 0;
    ticks(59);
    check("R11 oc count restarted", int'(fault_cause), 0);
    ticks(1);
    check("R11 oc trip after reset", int'(fault_cause), 1);
    check("R9 one pulse after reset", pulses, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule